// File: doc/BRIEF.md
# NOR Flash Sector-Erase and Byte-Program Sequencer

This block runs one sector erase or one single-byte program on a NOR flash device that uses the unlock-cycle command set. The caller pulses `start` with an operation select, a byte address and a data byte. The sequencer then drives the command writes over a byte-wide bus master port. It polls the device's status bits at the target address until the operation completes, fails or runs out of time. At the end it raises `done` for one cycle with a 2-bit result.

Completion is judged from the device's own status behaviour. For an erase, bit 6 stops alternating between consecutive reads. For a program, bit 7 of the read-back equals bit 7 of the written byte. When the device raises its internal time-limit flag (bit 5), the sequencer confirms with fresh reads before deciding. A cycle counter, loaded from a separate limit for each operation kind, bounds the polling phase. Looping over many bytes or blocks, and decoding addresses, belong to the caller.

Top module: `nor_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are low and `result` is 00.
- R2: Every operation's first bus transfer is a write of 0xF0 at address 0.
- R3: With `op_prog`=0 (erase), the writes after the first one are 0xAA@0xAAA, 0x55@0x554, 0x80@0xAAA, 0xAA@0xAAA, 0x55@0x554, then 0x30 at `tgt_addr`. Command offsets 0x555 and 0x2AA are shifted left by CMD_SHIFT (default 1).
- R4: With `op_prog`=1 (program), the writes after the first one are 0xAA@0xAAA, 0x55@0x554, 0xA0@0xAAA, then `wr_byte` at `tgt_addr`.
- R5: Every polling read is issued at `tgt_addr`. An erase succeeds (result 00) when bit 6 is equal in two consecutive reads.
- R6: During an erase, if bit 6 differs from the previous read and bit 5 is set, two further reads are made. The result is 01 (device fault) if their bit 6 differs, and 00 otherwise.
- R7: A program succeeds (result 00) when bit 7 of a read equals bit 7 of `wr_byte`.
- R8: During a program, if bit 7 mismatches and bit 5 is set, one further read is made. A bit-7 match gives 00 and a mismatch gives 01.
- R9: The timer counts clock cycles from the start of polling. If a polling read neither completes nor shows bit 5 while the count exceeds the limit, the result is 10 (timeout). An erase uses `erase_limit` and a program uses `prog_limit`.
- R10: A successful operation makes a final write of 0xF0 at address 0 before `done`. A failed one makes no further write.
- R11: `busy` is high from the cycle after an accepted `start` until the cycle of `done`. `done` lasts one cycle. A `start` while busy is ignored and starts no later operation.
- R12: Once raised, `bus_req` holds its address, data and direction unchanged until `bus_ack`, and drops the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_prog | input | 1 | 0 = sector erase, 1 = byte program |
| tgt_addr | input | ADDR_W | Sector or byte address |
| wr_byte | input | 8 | Byte to program |
| erase_limit | input | TMO_W | Polling cycle limit for erase |
| prog_limit | input | TMO_W | Polling cycle limit for program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 device fault, 10 timeout |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer acknowledge from the device side |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |

## Verification
A bench-side flash model alternates bit 6 (erase) or inverts bit 7 (program) for a chosen number of reads, and raises bit 5 from a chosen read onward. Sweeping both counts at random separates a clean finish, a confirmed success after the flag, and a confirmed fault, including the edge where the device settles exactly between the two confirmation reads. A device that never settles, run with a small limit for one operation kind and a large one for the other, shows that the timeout fires and picks the right limit. A start pulse injected mid-operation shows that it is ignored.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_FAULT   = 2'b01,
    RES_TIMEOUT = 2'b10
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_BASE,
    S_POLL,
    S_CHK_A,
    S_CHK_B,
    S_EXIT
  } fsm_e;

  localparam logic [7:0]  CMD_RESET    = 8'hF0;
  localparam logic [7:0]  CMD_UNLOCK1  = 8'hAA;
  localparam logic [7:0]  CMD_UNLOCK2  = 8'h55;
  localparam logic [7:0]  CMD_ERASE_ST = 8'h80;
  localparam logic [7:0]  CMD_SECTOR   = 8'h30;
  localparam logic [7:0]  CMD_PROG_ST  = 8'hA0;
  localparam logic [11:0] OFF_HI       = 12'h555;
  localparam logic [11:0] OFF_LO       = 12'h2AA;

  localparam int ERASE_STEPS = 7;
  localparam int PROG_STEPS  = 5;

endpackage

// File: rtl/nor_cmd_step.sv
module nor_cmd_step
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CMD_SHIFT = 1,
  parameter int STEP_W    = 3
) (
  input  logic              op_prog,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [7:0]        wbyte,
  output logic [ADDR_W-1:0] c_addr,
  output logic [7:0]        c_data,
  output logic              c_last
);

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFF_HI) << CMD_SHIFT;
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFF_LO) << CMD_SHIFT;
  localparam logic [STEP_W-1:0] LAST_E = STEP_W'(ERASE_STEPS - 1);
  localparam logic [STEP_W-1:0] LAST_P = STEP_W'(PROG_STEPS - 1);

  always_comb begin
    c_addr = '0;
    c_data = CMD_RESET;
    if (!op_prog) begin
      c_last = (step == LAST_E);
      case (step)
        3'd1:    begin c_addr = A_HI; c_data = CMD_UNLOCK1;  end
        3'd2:    begin c_addr = A_LO; c_data = CMD_UNLOCK2;  end
        3'd3:    begin c_addr = A_HI; c_data = CMD_ERASE_ST; end
        3'd4:    begin c_addr = A_HI; c_data = CMD_UNLOCK1;  end
        3'd5:    begin c_addr = A_LO; c_data = CMD_UNLOCK2;  end
        3'd6:    begin c_addr = tgt;  c_data = CMD_SECTOR;   end
        default: begin c_addr = '0;   c_data = CMD_RESET;    end
      endcase
    end else begin
      c_last = (step == LAST_P);
      case (step)
        3'd1:    begin c_addr = A_HI; c_data = CMD_UNLOCK1; end
        3'd2:    begin c_addr = A_LO; c_data = CMD_UNLOCK2; end
        3'd3:    begin c_addr = A_HI; c_data = CMD_PROG_ST; end
        3'd4:    begin c_addr = tgt;  c_data = wbyte;       end
        default: begin c_addr = '0;   c_data = CMD_RESET;   end
      endcase
    end
  end

endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval #(
  parameter int TGL_BIT  = 6,
  parameter int DATA_BIT = 7,
  parameter int FLAG_BIT = 5
) (
  input  logic       prev_tgl,
  input  logic [7:0] cur,
  input  logic       want_bit,
  output logic       settled,
  output logic       matched,
  output logic       dev_flag
);

  logic [7:0] cur_unused;

  assign settled    = (prev_tgl == cur[TGL_BIT]);
  assign matched    = (cur[DATA_BIT] == want_bit);
  assign dev_flag   = cur[FLAG_BIT];
  assign cur_unused = cur;

endmodule

// File: rtl/nor_timeout.sv
module nor_timeout #(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (!(&cnt))
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt > limit);

endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int TMO_W     = 24,
  parameter int CMD_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_prog,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        wr_byte,
  input  logic [TMO_W-1:0]  erase_limit,
  input  logic [TMO_W-1:0]  prog_limit,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);

  localparam int STEP_W = $clog2(ERASE_STEPS + 1);

  fsm_e              state;
  logic [STEP_W-1:0] step;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        byte_q;
  logic              prev_tgl;

  logic [ADDR_W-1:0] c_addr;
  logic [7:0]        c_data;
  logic              c_last;
  logic              settled, matched, dev_flag;
  logic              expired;
  logic              tmr_clr;
  logic [TMO_W-1:0]  lim_sel;
  logic              xfer_done;

  nor_cmd_step #(
    .ADDR_W(ADDR_W), .CMD_SHIFT(CMD_SHIFT), .STEP_W(STEP_W)
  ) u_cmd (
    .op_prog(op_q), .step(step), .tgt(addr_q), .wbyte(byte_q),
    .c_addr(c_addr), .c_data(c_data), .c_last(c_last)
  );

  nor_poll_eval u_eval (
    .prev_tgl(prev_tgl), .cur(bus_rdata), .want_bit(byte_q[7]),
    .settled(settled), .matched(matched), .dev_flag(dev_flag)
  );

  assign tmr_clr = (state == S_IDLE) || (state == S_CMD);
  assign lim_sel = op_q ? prog_limit : erase_limit;

  nor_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .clr(tmr_clr), .limit(lim_sel), .expired(expired)
  );

  assign xfer_done = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= '0;
      op_q      <= 1'b0;
      addr_q    <= '0;
      byte_q    <= '0;
      prev_tgl  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= RES_OK;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          op_q   <= op_prog;
          addr_q <= tgt_addr;
          byte_q <= wr_byte;
          step   <= '0;
          busy   <= 1'b1;
          state  <= S_CMD;
        end
      end else if (!bus_req) begin
        bus_req <= 1'b1;
        case (state)
          S_CMD: begin
            bus_we    <= 1'b1;
            bus_addr  <= c_addr;
            bus_wdata <= c_data;
          end
          S_EXIT: begin
            bus_we    <= 1'b1;
            bus_addr  <= '0;
            bus_wdata <= CMD_RESET;
          end
          default: begin
            bus_we    <= 1'b0;
            bus_addr  <= addr_q;
          end
        endcase
      end else if (xfer_done) begin
        bus_req <= 1'b0;
        case (state)
          S_CMD: begin
            if (c_last) state <= op_q ? S_POLL : S_BASE;
            else        step  <= step + 1'b1;
          end
          S_BASE: begin
            prev_tgl <= bus_rdata[6];
            state    <= S_POLL;
          end
          S_POLL: begin
            if (op_q ? matched : settled) begin
              state <= S_EXIT;
            end else if (dev_flag) begin
              state <= S_CHK_A;
            end else if (expired) begin
              state  <= S_IDLE;
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= RES_TIMEOUT;
            end else begin
              prev_tgl <= bus_rdata[6];
            end
          end
          S_CHK_A: begin
            if (!op_q) begin
              prev_tgl <= bus_rdata[6];
              state    <= S_CHK_B;
            end else if (matched) begin
              state <= S_EXIT;
            end else begin
              state  <= S_IDLE;
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= RES_FAULT;
            end
          end
          S_CHK_B: begin
            if (settled) begin
              state <= S_EXIT;
            end else begin
              state  <= S_IDLE;
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= RES_FAULT;
            end
          end
          S_EXIT: begin
            state  <= S_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= RES_OK;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R12
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !bus_req); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(addr_q) && $stable(op_q) && $stable(byte_q)); // R11
  AST_EXIT_ON_OK: assert property (@(posedge clk) disable iff (rst)
    done && result == RES_OK |-> $past(bus_req && bus_ack && bus_we && bus_wdata == CMD_RESET && bus_addr == '0)); // R10
  AST_FAIL_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    done && result != RES_OK |-> $past(bus_req && bus_ack && !bus_we)); // R10
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> result != 2'b11); // R9
  AST_POLL_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_we |-> bus_addr == addr_q); // R5

endmodule

// File: tb/nor_seq_bench.sv
`timescale 1ns/1ps
module nor_seq_bench;

  localparam int AW = 24;
  localparam int TW = 24;
  localparam int LOGN = 1024;

  logic          clk = 1'b0;
  logic          rst;
  logic          start, op_prog;
  logic [AW-1:0] tgt_addr;
  logic [7:0]    wr_byte;
  logic [TW-1:0] erase_limit, prog_limit;
  logic          busy, done;
  logic [1:0]    result;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_ack;
  logic [7:0]    bus_rdata;

  int nchecks = 0;
  int nerrors = 0;

  // flash model scenario
  bit          sc_prog;
  int          sc_busy, sc_flag;
  logic [7:0]  sc_data;
  logic [AW-1:0] sc_tgt;
  int          rd_n = 0, rd_base = 0, rd_bad = 0;
  int          wr_n = 0, wr_base = 0;
  logic [AW-1:0] wlog_a [LOGN];
  logic [7:0]    wlog_d [LOGN];

  always #2.5 clk = ~clk;

  nor_seq #(.ADDR_W(AW), .TMO_W(TW), .CMD_SHIFT(1)) u_nor_seq (
    .clk(clk), .rst(rst), .start(start), .op_prog(op_prog),
    .tgt_addr(tgt_addr), .wr_byte(wr_byte),
    .erase_limit(erase_limit), .prog_limit(prog_limit),
    .busy(busy), .done(done), .result(result),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // n-th read value of the device model
  function automatic logic [7:0] mval(bit prog, int n, int nb, int nf, logic [7:0] d);
    logic fl;
    fl = (n >= nf);
    if (!prog) return (n < nb) ? {1'b0, n[0], fl, 5'b0} : 8'hFF;
    return (n < nb) ? {~d[7], 1'b0, fl, 5'b0} : d;
  endfunction

  // expected result from the polling rules (R5-R8), no timeout
  function automatic logic [1:0] ref_res(bit prog, int nb, int nf, logic [7:0] d);
    int i;
    logic [7:0] p, c, a, b;
    i = 0;
    if (!prog) begin
      p = mval(0, i, nb, nf, d); i++;
      for (int k = 0; k < 400; k++) begin
        c = mval(0, i, nb, nf, d); i++;
        if (c[6] == p[6]) return 2'b00;
        if (c[5]) begin
          a = mval(0, i, nb, nf, d); i++;
          b = mval(0, i, nb, nf, d); i++;
          return (a[6] != b[6]) ? 2'b01 : 2'b00;
        end
        p = c;
      end
    end else begin
      for (int k = 0; k < 400; k++) begin
        c = mval(1, i, nb, nf, d); i++;
        if (c[7] == d[7]) return 2'b00;
        if (c[5]) begin
          a = mval(1, i, nb, nf, d);
          return (a[7] == d[7]) ? 2'b00 : 2'b01;
        end
      end
    end
    return 2'b10;
  endfunction

  function automatic logic [AW-1:0] exp_wa(bit prog, int i, logic [AW-1:0] a);
    if (!prog) begin
      case (i)
        1, 3, 4: return 24'hAAA;
        2, 5:    return 24'h554;
        6:       return a;
        default: return 24'h0;
      endcase
    end
    case (i)
      1, 3:    return 24'hAAA;
      2:       return 24'h554;
      4:       return a;
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_wd(bit prog, int i, logic [7:0] d);
    if (!prog) begin
      case (i)
        1, 4:    return 8'hAA;
        2, 5:    return 8'h55;
        3:       return 8'h80;
        6:       return 8'h30;
        default: return 8'hF0;
      endcase
    end
    case (i)
      1:       return 8'hAA;
      2:       return 8'h55;
      3:       return 8'hA0;
      4:       return d;
      default: return 8'hF0;
    endcase
  endfunction

  // device side of the bus
  always @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 8'h00;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        wlog_a[wr_n % LOGN] <= bus_addr;
        wlog_d[wr_n % LOGN] <= bus_wdata;
        wr_n <= wr_n + 1;
      end else begin
        bus_rdata <= mval(sc_prog, rd_n - rd_base, sc_busy, sc_flag, sc_data);
        if (bus_addr != sc_tgt) rd_bad <= rd_bad + 1;
        rd_n <= rd_n + 1;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic run_op(bit prog, logic [AW-1:0] a, logic [7:0] d, int nb, int nf,
                        int le, int lp, logic [1:0] expr, bit poke);
    int cyc, nw, ew, bad0;
    bit got;
    @(negedge clk);
    sc_prog = prog; sc_busy = nb; sc_flag = nf; sc_data = d; sc_tgt = a;
    rd_base = rd_n; wr_base = wr_n; bad0 = rd_bad;
    op_prog = prog; tgt_addr = a; wr_byte = d;
    erase_limit = TW'(le); prog_limit = TW'(lp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    got = 1'b0;
    for (cyc = 0; cyc < 20000; cyc++) begin
      if (poke && cyc == 4) begin
        start = 1'b1; op_prog = ~prog; tgt_addr = a ^ 24'h00F00F; wr_byte = ~d;
      end else begin
        start = 1'b0;
      end
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    check(got, "R11 done reached", got, 1);
    check(busy == 1'b0, "R11 busy low at done", busy, 0);
    check(result == expr, prog ? "R7/R8/R9 program result" : "R5/R6/R9 erase result",
          result, expr);
    check(rd_bad == bad0, "R5 poll reads at target", rd_bad - bad0, 0);
    nw = wr_n - wr_base;
    ew = (prog ? 5 : 7) + ((expr == 2'b00) ? 1 : 0);
    check(nw == ew, "R10 write count", nw, ew);
    for (int i = 0; i < nw && i < ew; i++) begin
      check(wlog_a[(wr_base + i) % LOGN] == exp_wa(prog, i, a),
            prog ? "R2/R4 program write addr" : "R2/R3 erase write addr",
            wlog_a[(wr_base + i) % LOGN], exp_wa(prog, i, a));
      check(wlog_d[(wr_base + i) % LOGN] == exp_wd(prog, i, d),
            prog ? "R2/R4 program write data" : "R2/R3 erase write data",
            wlog_d[(wr_base + i) % LOGN], exp_wd(prog, i, d));
    end
    @(negedge clk);
    check(done == 1'b0, "R11 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && bus_req == 1'b0, "R11 no later operation", {busy, bus_req}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; op_prog = 1'b0; tgt_addr = '0; wr_byte = '0;
    erase_limit = '0; prog_limit = '0;
    sc_prog = 0; sc_busy = 0; sc_flag = 100; sc_data = 0; sc_tgt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && bus_req == 0, "R1 reset outputs",
          {busy, done, bus_req}, 0);
    check(result == 2'b00, "R1 reset result", result, 0);

    // R5 erase settles cleanly
    run_op(0, 24'h120000, 8'h00, 5, 1000, 100000, 100000, ref_res(0, 5, 1000, 8'h00), 0);
    // R6 flag while toggling, still toggling -> fault
    run_op(0, 24'h040000, 8'h00, 50, 3, 100000, 100000, 2'b01, 0);
    // R6 flag, settles right before confirmation -> ok
    run_op(0, 24'h080000, 8'h00, 3, 2, 100000, 100000, ref_res(0, 3, 2, 8'h00), 0);
    // R7 program clean
    run_op(1, 24'h000123, 8'h5A, 4, 1000, 100000, 100000, 2'b00, 0);
    run_op(1, 24'h000124, 8'hC3, 0, 1000, 100000, 100000, 2'b00, 0);
    // R8 flag then match / mismatch
    run_op(1, 24'h000200, 8'h81, 3, 2, 100000, 100000, 2'b00, 0);
    run_op(1, 24'h000201, 8'h81, 50, 2, 100000, 100000, 2'b01, 0);
    // R9 timeouts and limit selection
    run_op(0, 24'h100000, 8'h00, 1000000, 1000000, 20, 100000, 2'b10, 0);
    run_op(1, 24'h100010, 8'h7E, 1000000, 1000000, 100000, 20, 2'b10, 0);
    run_op(1, 24'h100020, 8'h7E, 30, 1000000, 20, 100000, 2'b00, 0);
    run_op(0, 24'h100030, 8'h00, 30, 1000000, 100000, 20, ref_res(0, 30, 1000000, 8'h00), 0);
    // R11 start while busy ignored
    run_op(1, 24'h0ABCDE, 8'h3C, 6, 1000, 100000, 100000, 2'b00, 1);
    run_op(0, 24'h0F0000, 8'h00, 8, 1000, 100000, 100000, ref_res(0, 8, 1000, 8'h00), 1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      bit p;
      logic [AW-1:0] a;
      logic [7:0] d;
      int nb, nf;
      p  = 1'($urandom % 2);
      a  = AW'($urandom);
      d  = 8'($urandom);
      nb = int'($urandom % 14);
      nf = int'($urandom % 16);
      run_op(p, a, d, nb, nf, 100000, 100000, ref_res(p, nb, nf, d), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule